// File: doc/BRIEF.md
# Byte ALU with Per-Operation Flag Update

This block is the arithmetic and logic datapath of a small register-file microcontroller core. Each cycle it takes an operation code and two byte operands, which may come from registers or from an immediate. It also takes the six status flags as they stand, a 16-bit register pair, and a short unsigned constant for the word operations. From these it produces a result, the new flag byte, a per-flag write mask and a result write enable. All of these are registered, so they appear one clock after the inputs.

Each operation writes only its own subset of flags. Every flag bit that is outside the mask is handed through unchanged from the incoming flags. The core's flag register can therefore load the flag output directly, or it can merge the flags under the mask. Subtract-with-carry and compare-with-carry carry the zero flag forward, so a zero test over a multibyte value built from a chain of these operations gives the right answer.

Top module: `byte_alu`

## Requirements
- R1: Flag bit positions are C=0, Z=1, N=2, V=3, S=4, H=5. All outputs are registered with one cycle of latency. While `rst` is high, all outputs read zero.
- R2: Add and add-with-carry return the low byte of a+b (plus C for the carry form). They write C (carry out of bit 7), H (carry out of bit 3), Z, N, V (signed overflow) and S.
- R3: Subtract and subtract-with-carry return a-b (minus C for the carry form). They write C and H as the borrow out of bit 7 and out of bit 3, and also write Z, N, V and S.
- R4: For subtract-with-carry and compare-with-carry, Z is 1 only when the result is zero and the incoming Z was already 1.
- R5: Compare and compare-with-carry produce the subtraction flags exactly as R3 and R4 describe, with `res_we_o` held at 0.
- R6: AND, OR, XOR, set-mask (a OR b), clear-mask (a AND NOT b), test (result a), zero and all-ones write only Z, N, V and S, with V=0. C and H are left unwritten.
- R7: Increment and decrement write only Z, N, V and S. V=1 only for increment of 0x7F and for decrement of 0x80.
- R8: One's complement returns 0xFF-a with C=1 and V=0, and writes C, Z, N, V and S. Two's complement returns 0x00-a with C=1 exactly when the result is nonzero, and writes all six flags.
- R9: Shift-left fills bit 0 with 0 and shift-right fills bit 7 with 0. Rotate-left moves the old C into bit 0. C receives the bit shifted out, V=N XOR C, and the writes are C, Z, N, V and S.
- R10: Word add and word subtract apply the constant to the 16-bit pair and return the 16-bit result. They write C (carry or borrow out of bit 15), Z, N (bit 15), V and S, and never H.
- R11: Every flag bit whose `flag_we_o` bit is 0 equals the corresponding bit of `flags_i` from the previous cycle.
- R12: Whenever S is written, it equals N XOR V.
- R13: Opcodes outside the defined set write nothing: the mask is zero, `res_we_o` is 0 and the result is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_code | input | 5 | Operation select (package enum) |
| opa_i | input | DW | First operand / destination value |
| opb_i | input | DW | Second operand or immediate |
| flags_i | input | 6 | Current flags |
| pair_i | input | 2*DW | Register pair for word operations |
| kimm_i | input | KW | Unsigned word constant |
| res_o | output | 2*DW | Result (byte results zero-extended) |
| res_we_o | output | 1 | Result should be written back |
| flags_o | output | 6 | Flags after the operation |
| flag_we_o | output | 6 | Flags this operation wrote |

## Verification
The bench builds the block with its defaults, DW=8 and KW=6. At these values the byte edges (0x7F, 0x80, 0xFF) are all reachable, as is the half-carry at bit 3. The 16-bit wrap points 0x7FFF and 0xFFFF are reached through a constant as small as 1. A scoreboard model, written with signed integer arithmetic, predicts the result, the flags and the mask for directed corner cases and for several hundred random operations. Those random operations cover every opcode and include undefined codes.

// File: rtl/byte_alu_pkg.sv
package byte_alu_pkg;
  localparam int NFLAG = 6;
  localparam int FC = 0;
  localparam int FZ = 1;
  localparam int FN = 2;
  localparam int FV = 3;
  localparam int FS = 4;
  localparam int FH = 5;

  typedef logic [NFLAG-1:0] flags_t;

  localparam flags_t M_ZNVS  = 6'b011110;
  localparam flags_t M_ZNVSC = 6'b011111;
  localparam flags_t M_ALL   = 6'b111111;

  typedef enum logic [4:0] {
    OP_ADD     = 5'd0,
    OP_ADDC    = 5'd1,
    OP_SUB     = 5'd2,
    OP_SUBC    = 5'd3,
    OP_CMP     = 5'd4,
    OP_CMPC    = 5'd5,
    OP_AND     = 5'd6,
    OP_OR      = 5'd7,
    OP_XOR     = 5'd8,
    OP_SETMASK = 5'd9,
    OP_CLRMASK = 5'd10,
    OP_TEST    = 5'd11,
    OP_ZERO    = 5'd12,
    OP_ONES    = 5'd13,
    OP_INC     = 5'd14,
    OP_DEC     = 5'd15,
    OP_CPL     = 5'd16,
    OP_NEGATE  = 5'd17,
    OP_SHL     = 5'd18,
    OP_SHR     = 5'd19,
    OP_ROTL    = 5'd20,
    OP_WADD    = 5'd21,
    OP_WSUB    = 5'd22
  } alu_op_e;
endpackage

// File: rtl/byte_alu_arith.sv
module byte_alu_arith #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cin,
  input  logic          sub,
  input  logic          zin,
  input  logic          zchain,
  output logic [DW-1:0] r,
  output logic          c,
  output logic          h,
  output logic          v,
  output logic          z
);
  localparam int HB = DW/2 - 1;

  logic [DW:0]   ext;
  logic [HB+1:0] lo;

  always_comb begin
    if (sub) begin
      ext = {1'b0, a} - {1'b0, b} - {{DW{1'b0}}, cin};
      lo  = {1'b0, a[HB:0]} - {1'b0, b[HB:0]} - {{(HB+1){1'b0}}, cin};
    end else begin
      ext = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cin};
      lo  = {1'b0, a[HB:0]} + {1'b0, b[HB:0]} + {{(HB+1){1'b0}}, cin};
    end
    r = ext[DW-1:0];
    c = ext[DW];
    h = lo[HB+1];
    if (sub) v = (a[DW-1] != b[DW-1]) && (r[DW-1] != a[DW-1]);
    else     v = (a[DW-1] == b[DW-1]) && (r[DW-1] != a[DW-1]);
    z = (r == '0) && (!zchain || zin);
  end
endmodule

// File: rtl/byte_alu_logic.sv
module byte_alu_logic
  import byte_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  alu_op_e       op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] r
);
  always_comb begin
    case (op)
      OP_AND:     r = a & b;
      OP_OR:      r = a | b;
      OP_SETMASK: r = a | b;
      OP_XOR:     r = a ^ b;
      OP_CLRMASK: r = a & ~b;
      OP_TEST:    r = a;
      OP_ONES:    r = '1;
      OP_CPL:     r = ~a;
      default:    r = '0;
    endcase
  end
endmodule

// File: rtl/byte_alu_shift.sv
module byte_alu_shift
  import byte_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  alu_op_e       op,
  input  logic [DW-1:0] a,
  input  logic          cin,
  output logic [DW-1:0] r,
  output logic          c
);
  always_comb begin
    case (op)
      OP_SHR: begin
        r = {1'b0, a[DW-1:1]};
        c = a[0];
      end
      OP_ROTL: begin
        r = {a[DW-2:0], cin};
        c = a[DW-1];
      end
      default: begin
        r = {a[DW-2:0], 1'b0};
        c = a[DW-1];
      end
    endcase
  end
endmodule

// File: rtl/byte_alu_word.sv
module byte_alu_word #(
  parameter int DW = 8,
  parameter int KW = 6
) (
  input  logic [2*DW-1:0] pair,
  input  logic [KW-1:0]   k,
  input  logic            sub,
  output logic [2*DW-1:0] r,
  output logic            c,
  output logic            v
);
  localparam int PW = 2*DW;

  logic [PW:0] ext;
  logic [PW:0] kext;

  always_comb begin
    kext = {{(PW+1-KW){1'b0}}, k};
    if (sub) ext = {1'b0, pair} - kext;
    else     ext = {1'b0, pair} + kext;
    r = ext[PW-1:0];
    c = ext[PW];
    if (sub) v = pair[PW-1] && !r[PW-1];
    else     v = !pair[PW-1] && r[PW-1];
  end
endmodule

// File: rtl/byte_alu.sv
module byte_alu
  import byte_alu_pkg::*;
#(
  parameter int DW = 8,
  parameter int KW = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [4:0]      op_code,
  input  logic [DW-1:0]   opa_i,
  input  logic [DW-1:0]   opb_i,
  input  logic [5:0]      flags_i,
  input  logic [2*DW-1:0] pair_i,
  input  logic [KW-1:0]   kimm_i,
  output logic [2*DW-1:0] res_o,
  output logic            res_we_o,
  output logic [5:0]      flags_o,
  output logic [5:0]      flag_we_o
);
  localparam int PW = 2*DW;
  localparam logic [DW-1:0] ONE = {{(DW-1){1'b0}}, 1'b1};

  alu_op_e op_e;
  assign op_e = alu_op_e'(op_code);

  logic [DW-1:0] ar_a, ar_b, ar_r;
  logic          ar_cin, ar_sub, ar_chain, ar_c, ar_h, ar_v, ar_z;
  logic [DW-1:0] lg_r, sh_r;
  logic          sh_c;
  logic [PW-1:0] wd_r;
  logic          wd_c, wd_v;

  always_comb begin
    ar_a     = opa_i;
    ar_b     = opb_i;
    ar_cin   = 1'b0;
    ar_sub   = 1'b0;
    ar_chain = 1'b0;
    case (op_e)
      OP_ADDC: ar_cin = flags_i[FC];
      OP_SUB, OP_CMP: ar_sub = 1'b1;
      OP_SUBC, OP_CMPC: begin
        ar_sub   = 1'b1;
        ar_cin   = flags_i[FC];
        ar_chain = 1'b1;
      end
      OP_NEGATE: begin
        ar_a   = '0;
        ar_b   = opa_i;
        ar_sub = 1'b1;
      end
      OP_INC: ar_b = ONE;
      OP_DEC: begin
        ar_b   = ONE;
        ar_sub = 1'b1;
      end
      default: ;
    endcase
  end

  byte_alu_arith #(.DW(DW)) u_arith (
    .a(ar_a), .b(ar_b), .cin(ar_cin), .sub(ar_sub), .zin(flags_i[FZ]),
    .zchain(ar_chain), .r(ar_r), .c(ar_c), .h(ar_h), .v(ar_v), .z(ar_z)
  );

  byte_alu_logic #(.DW(DW)) u_logic (
    .op(op_e), .a(opa_i), .b(opb_i), .r(lg_r)
  );

  byte_alu_shift #(.DW(DW)) u_shift (
    .op(op_e), .a(opa_i), .cin(flags_i[FC]), .r(sh_r), .c(sh_c)
  );

  byte_alu_word #(.DW(DW), .KW(KW)) u_word (
    .pair(pair_i), .k(kimm_i), .sub(op_e == OP_WSUB), .r(wd_r), .c(wd_c), .v(wd_v)
  );

  logic [PW-1:0] res_n;
  logic          we_n;
  flags_t        nf, mask;

  always_comb begin
    res_n = '0;
    we_n  = 1'b0;
    nf    = '0;
    mask  = '0;
    case (op_e)
      OP_ADD, OP_ADDC, OP_SUB, OP_SUBC, OP_NEGATE, OP_CMP, OP_CMPC: begin
        res_n  = {{DW{1'b0}}, ar_r};
        we_n   = !(op_e == OP_CMP || op_e == OP_CMPC);
        nf[FC] = ar_c;
        nf[FH] = ar_h;
        nf[FV] = ar_v;
        nf[FZ] = ar_z;
        nf[FN] = ar_r[DW-1];
        mask   = M_ALL;
      end
      OP_INC, OP_DEC: begin
        res_n  = {{DW{1'b0}}, ar_r};
        we_n   = 1'b1;
        nf[FV] = ar_v;
        nf[FZ] = ar_z;
        nf[FN] = ar_r[DW-1];
        mask   = M_ZNVS;
      end
      OP_AND, OP_OR, OP_XOR, OP_SETMASK, OP_CLRMASK, OP_TEST, OP_ZERO, OP_ONES: begin
        res_n  = {{DW{1'b0}}, lg_r};
        we_n   = 1'b1;
        nf[FZ] = (lg_r == '0);
        nf[FN] = lg_r[DW-1];
        mask   = M_ZNVS;
      end
      OP_CPL: begin
        res_n  = {{DW{1'b0}}, lg_r};
        we_n   = 1'b1;
        nf[FC] = 1'b1;
        nf[FZ] = (lg_r == '0);
        nf[FN] = lg_r[DW-1];
        mask   = M_ZNVSC;
      end
      OP_SHL, OP_SHR, OP_ROTL: begin
        res_n  = {{DW{1'b0}}, sh_r};
        we_n   = 1'b1;
        nf[FC] = sh_c;
        nf[FZ] = (sh_r == '0);
        nf[FN] = sh_r[DW-1];
        nf[FV] = sh_r[DW-1] ^ sh_c;
        mask   = M_ZNVSC;
      end
      OP_WADD, OP_WSUB: begin
        res_n  = wd_r;
        we_n   = 1'b1;
        nf[FC] = wd_c;
        nf[FV] = wd_v;
        nf[FZ] = (wd_r == '0);
        nf[FN] = wd_r[PW-1];
        mask   = M_ZNVSC;
      end
      default: ;
    endcase
    nf[FS] = nf[FN] ^ nf[FV];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o     <= '0;
      res_we_o  <= 1'b0;
      flags_o   <= '0;
      flag_we_o <= '0;
    end else begin
      res_o     <= res_n;
      res_we_o  <= we_n;
      flags_o   <= (mask & nf) | (~mask & flags_i);
      flag_we_o <= mask;
    end
  end
endmodule

// File: rtl/byte_alu_chk.sv
module byte_alu_chk
  import byte_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic [4:0]    op_code,
  input logic [DW-1:0] opa_i,
  input logic [5:0]    flags_i,
  input logic          res_we_o,
  input logic [5:0]    flags_o,
  input logic [5:0]    flag_we_o
);
  localparam logic [DW-1:0] MAXPOS = {1'b0, {(DW-1){1'b1}}};

  AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(op_code) == OP_CMP || $past(op_code) == OP_CMPC)) |-> !res_we_o); // R5

  AST_LOGIC_KEEPS_CH: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(op_code) == OP_AND || $past(op_code) == OP_OR || $past(op_code) == OP_XOR))
      |-> (!flag_we_o[FC] && !flag_we_o[FH])); // R6

  AST_INC_OVF: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_code) == OP_INC && $past(opa_i) == MAXPOS) |-> flags_o[FV]); // R7

  AST_CPL_CARRY: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_code) == OP_CPL) |-> flags_o[FC]); // R8

  AST_CHAIN_Z: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_code) == OP_SUBC && !$past(flags_i[FZ])) |-> !flags_o[FZ]); // R4

  AST_S_TRACKS: assert property (@(posedge clk) disable iff (rst)
    flag_we_o[FS] |-> (flags_o[FS] == (flags_o[FN] ^ flags_o[FV]))); // R12

  AST_PASS_THRU: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !flag_we_o[FH]) |-> (flags_o[FH] == $past(flags_i[FH]))); // R11
endmodule

bind byte_alu byte_alu_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .op_code(op_code), .opa_i(opa_i), .flags_i(flags_i),
  .res_we_o(res_we_o), .flags_o(flags_o), .flag_we_o(flag_we_o)
);

// File: tb/test_byte_alu.sv
module test_byte_alu;
  import byte_alu_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  op_code = '0;
  logic [7:0]  opa_i = '0, opb_i = '0;
  logic [5:0]  flags_i = '0;
  logic [15:0] pair_i = '0;
  logic [5:0]  kimm_i = '0;
  logic [15:0] res_o;
  logic        res_we_o;
  logic [5:0]  flags_o, flag_we_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  byte_alu #(.DW(8), .KW(6)) i_byte_alu (
    .clk(clk), .rst(rst), .op_code(op_code), .opa_i(opa_i), .opb_i(opb_i),
    .flags_i(flags_i), .pair_i(pair_i), .kimm_i(kimm_i), .res_o(res_o),
    .res_we_o(res_we_o), .flags_o(flags_o), .flag_we_o(flag_we_o)
  );

  typedef struct {
    logic [15:0] res;
    logic        we;
    logic [5:0]  fl;
    logic [5:0]  m;
    string       tag;
  } exp_t;

  exp_t sbq[$];

  function automatic int sg8(int x);
    return (x > 127) ? x - 256 : x;
  endfunction

  function automatic int sg16(int x);
    return (x > 32767) ? x - 65536 : x;
  endfunction

  function automatic string tag_of(logic [4:0] op);
    case (op)
      OP_ADD, OP_ADDC: return "R2";
      OP_SUB: return "R3";
      OP_SUBC: return "R4";
      OP_CMP, OP_CMPC: return "R5";
      OP_INC, OP_DEC: return "R7";
      OP_CPL, OP_NEGATE: return "R8";
      OP_SHL, OP_SHR, OP_ROTL: return "R9";
      OP_WADD, OP_WSUB: return "R10";
      OP_AND, OP_OR, OP_XOR, OP_SETMASK, OP_CLRMASK, OP_TEST, OP_ZERO, OP_ONES: return "R6";
      default: return "R13";
    endcase
  endfunction

  function automatic exp_t model(logic [4:0] op, int a, int b, logic [5:0] f, int p, int k);
    exp_t e;
    int t, r, sv, cin, x, y;
    logic [5:0] nf, m;
    bit chain, word;
    nf = '0; m = '0; r = 0; e.we = 1'b0; chain = 1'b0; word = 1'b0; cin = 0;
    case (op)
      OP_ADD, OP_ADDC: begin
        cin = (op == OP_ADDC) ? int'(f[0]) : 0;
        t = a + b + cin; r = t % 256;
        nf[0] = (t > 255);
        nf[5] = ((a % 16) + (b % 16) + cin) > 15;
        sv = sg8(a) + sg8(b) + cin;
        nf[3] = (sv > 127) || (sv < -128);
        m = 6'h3F; e.we = 1'b1;
      end
      OP_SUB, OP_SUBC, OP_CMP, OP_CMPC, OP_NEGATE: begin
        x = a; y = b;
        if (op == OP_NEGATE) begin x = 0; y = a; end
        if (op == OP_SUBC || op == OP_CMPC) begin cin = int'(f[0]); chain = 1'b1; end
        t = x - y - cin; r = (t + 512) % 256;
        nf[0] = (t < 0);
        nf[5] = ((x % 16) - (y % 16) - cin) < 0;
        sv = sg8(x) - sg8(y) - cin;
        nf[3] = (sv > 127) || (sv < -128);
        m = 6'h3F; e.we = !(op == OP_CMP || op == OP_CMPC);
      end
      OP_INC: begin r = (a + 1) % 256; nf[3] = (sg8(a) + 1) > 127; m = 6'h1E; e.we = 1'b1; end
      OP_DEC: begin r = (a + 255) % 256; nf[3] = (sg8(a) - 1) < -128; m = 6'h1E; e.we = 1'b1; end
      OP_AND:     begin r = a & b;         m = 6'h1E; e.we = 1'b1; end
      OP_OR:      begin r = a | b;         m = 6'h1E; e.we = 1'b1; end
      OP_SETMASK: begin r = a | b;         m = 6'h1E; e.we = 1'b1; end
      OP_XOR:     begin r = a ^ b;         m = 6'h1E; e.we = 1'b1; end
      OP_CLRMASK: begin r = a & (255 - b); m = 6'h1E; e.we = 1'b1; end
      OP_TEST:    begin r = a;             m = 6'h1E; e.we = 1'b1; end
      OP_ZERO:    begin r = 0;             m = 6'h1E; e.we = 1'b1; end
      OP_ONES:    begin r = 255;           m = 6'h1E; e.we = 1'b1; end
      OP_CPL:     begin r = 255 - a; nf[0] = 1'b1; m = 6'h1F; e.we = 1'b1; end
      OP_SHL:  begin r = (a * 2) % 256; nf[0] = (a >= 128); m = 6'h1F; e.we = 1'b1; end
      OP_SHR:  begin r = a / 2; nf[0] = (a % 2) == 1; m = 6'h1F; e.we = 1'b1; end
      OP_ROTL: begin r = (a * 2) % 256 + int'(f[0]); nf[0] = (a >= 128); m = 6'h1F; e.we = 1'b1; end
      OP_WADD: begin
        t = p + k; r = t % 65536; nf[0] = (t > 65535);
        sv = sg16(p) + k; nf[3] = (sv > 32767);
        word = 1'b1; m = 6'h1F; e.we = 1'b1;
      end
      OP_WSUB: begin
        t = p - k; r = (t + 65536) % 65536; nf[0] = (t < 0);
        sv = sg16(p) - k; nf[3] = (sv < -32768);
        word = 1'b1; m = 6'h1F; e.we = 1'b1;
      end
      default: ;
    endcase
    nf[1] = (r == 0) && (!chain || f[1]);
    nf[2] = word ? (r >= 32768) : (r >= 128);
    if (op == OP_SHL || op == OP_SHR || op == OP_ROTL) nf[3] = nf[2] ^ nf[0];
    nf[4] = nf[2] ^ nf[3];
    e.res = r[15:0];
    e.m   = m;
    e.fl  = (m & nf) | (~m & f);
    return e;
  endfunction

  task automatic send(input logic [4:0] op, input logic [7:0] a, input logic [7:0] b,
                      input logic [5:0] f, input logic [15:0] p, input logic [5:0] k,
                      input string tag);
    exp_t e;
    @(negedge clk);
    op_code = op; opa_i = a; opb_i = b; flags_i = f; pair_i = p; kimm_i = k;
    e = model(op, int'(a), int'(b), f, int'(p), int'(k));
    e.tag = tag;
    sbq.push_back(e);
  endtask

  // monitor: compares each registered result one clock after it was driven (R1 latency)
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sbq.size() > 0) begin
        exp_t e;
        e = sbq.pop_front();
        n_cmp++;
        if (res_o !== e.res || res_we_o !== e.we || flags_o !== e.fl || flag_we_o !== e.m) begin
          n_bad++;
          $display("FAIL %s res=%h/%b flags=%b mask=%b expected res=%h/%b flags=%b mask=%b",
                   e.tag, res_o, res_we_o, flags_o, flag_we_o, e.res, e.we, e.fl, e.m);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    n_cmp++;
    if (res_o !== '0 || res_we_o !== 1'b0 || flags_o !== '0 || flag_we_o !== '0) begin
      n_bad++;
      $display("FAIL R1 reset outputs res=%h we=%b flags=%b mask=%b expected all zero",
               res_o, res_we_o, flags_o, flag_we_o);
    end
    rst = 1'b0;

    send(OP_ADD,  8'h7F, 8'h01, 6'b000000, 16'h0, 6'h0, "R2 overflow+half");
    send(OP_ADD,  8'hFF, 8'h01, 6'b000000, 16'h0, 6'h0, "R2 carry+zero");
    send(OP_ADDC, 8'h0F, 8'h00, 6'b000001, 16'h0, 6'h0, "R2 carry in");
    send(OP_SUB,  8'h00, 8'h01, 6'b000000, 16'h0, 6'h0, "R3 borrow");
    send(OP_SUBC, 8'h10, 8'h0F, 6'b000001, 16'h0, 6'h0, "R3 R4 borrow in, Z was 0");
    send(OP_SUBC, 8'h10, 8'h0F, 6'b000011, 16'h0, 6'h0, "R4 chained zero");
    send(OP_CMP,  8'h40, 8'h40, 6'b100000, 16'h0, 6'h0, "R5 equal");
    send(OP_CMPC, 8'h05, 8'h05, 6'b000000, 16'h0, 6'h0, "R5 R4 compare chain");
    send(OP_AND,  8'hF0, 8'h0F, 6'b100001, 16'h0, 6'h0, "R6 R11 C,H kept");
    send(OP_CLRMASK, 8'hFF, 8'h81, 6'b001000, 16'h0, 6'h0, "R6 clear mask");
    send(OP_ONES, 8'h00, 8'h00, 6'b001000, 16'h0, 6'h0, "R6 R12 all-ones");
    send(OP_INC,  8'h7F, 8'h00, 6'b100001, 16'h0, 6'h0, "R7 inc overflow");
    send(OP_DEC,  8'h80, 8'h00, 6'b000000, 16'h0, 6'h0, "R7 dec overflow");
    send(OP_DEC,  8'h01, 8'h00, 6'b001000, 16'h0, 6'h0, "R7 dec to zero");
    send(OP_CPL,  8'hFF, 8'h00, 6'b000000, 16'h0, 6'h0, "R8 complement zero");
    send(OP_NEGATE, 8'h00, 8'h00, 6'b000001, 16'h0, 6'h0, "R8 negate zero");
    send(OP_NEGATE, 8'h80, 8'h00, 6'b000000, 16'h0, 6'h0, "R8 negate 0x80");
    send(OP_SHL,  8'h81, 8'h00, 6'b000000, 16'h0, 6'h0, "R9 shift left");
    send(OP_SHR,  8'h01, 8'h00, 6'b000000, 16'h0, 6'h0, "R9 shift right");
    send(OP_ROTL, 8'h40, 8'h00, 6'b000001, 16'h0, 6'h0, "R9 rotate");
    send(OP_WADD, 8'h00, 8'h00, 6'b100000, 16'hFFFF, 6'h01, "R10 word wrap");
    send(OP_WADD, 8'h00, 8'h00, 6'b000000, 16'h7FFF, 6'h01, "R10 word overflow");
    send(OP_WSUB, 8'h00, 8'h00, 6'b000000, 16'h0000, 6'h01, "R10 word borrow");
    send(OP_WSUB, 8'h00, 8'h00, 6'b000000, 16'h8000, 6'h3F, "R10 word neg overflow");
    send(5'd30,   8'h55, 8'hAA, 6'b101010, 16'h1234, 6'h05, "R13 undefined code");

    for (int i = 0; i < 600; i++) begin
      logic [4:0] op;
      op = (i % 40 == 39) ? 5'(23 + (i % 9)) : 5'($urandom_range(0, 22));
      send(op, 8'($urandom), 8'($urandom), 6'($urandom), 16'($urandom), 6'($urandom), tag_of(op));
    end

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule